// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block sits between a host request port and a narrow 32-bit bus transaction port. The host cannot issue byte or halfword cycles directly, so it encodes them in the address. Each host offset into a sparse region holds the bus address shifted left by five bits, and the bits below that shift carry the transfer size. The translator recovers the bus address, the size and the byte lane from that offset. It builds active-low byte enables, moves write data into its lane, and returns read data moved down to bit 0.

Memory sparse requests carry only the low 26 bus address bits. The top three bits come from an extension register that has its own write port, and the three bits just below them are forced to zero. I/O sparse requests use the same encoding without the extension register. A 64-bit request becomes two longword transactions, low half first. Encodings that cannot be carried are refused with an error pulse.

All data interfaces follow valid/ready rules. A host request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no transaction is in flight. A bus transaction, and a read response to the host, keep every field steady until the consumer raises its ready. A bus completion (`cpl_valid`) has no back-pressure: it is a one-cycle pulse, and it is used only while a read is waiting for it.

Top module: `sparse_xlat`

## Requirements
- R1: For a memory request the bus address is {ext[2:0], 3'b000, host_offset[30:5]}, where ext is the extension register value.
- R2: The size code sits in host offset bits 4:3, with 00 = byte, 01 = 16-bit word and 11 = 32-bit longword. The byte position is host offset bits 6:5, which are the two low bus address bits.
- R3: Byte enables are active low: ~(0001<<pos) for a byte, ~(0011<<pos) for a word, and 0000 for a longword.
- R4: Write data is masked to its size and shifted left by 8*pos onto the bus data.
- R5: Read completion data is shifted right by 8*pos, masked to the size and zero-extended into rsp_data. For a longword the data is returned whole.
- R6: A request with req_quad set and the longword code makes two transactions. The first goes to the decoded address and carries req_wdata[31:0]. The second goes to the low address field plus 4 and carries req_wdata[63:32]. A quad read returns {second completion, first completion}.
- R7: An I/O request drives txn_io high and bus address bits 31:26 to zero, whatever the extension register holds.
- R8: A word at position 3, size code 10, or req_quad with any code other than longword is refused. req_err goes high for the single cycle after acceptance, no transaction is issued, and req_ready stays high.
- R9: The extension register resets to zero and is loaded by ext_we. A request accepted in the same cycle as an ext_we write uses the old value, and later requests use the new one.
- R10: While txn_valid is high and txn_ready is low, the address, enables and data hold steady. The same holds for rsp_data while rsp_valid is high and rsp_ready is low. req_ready is low while a transaction or response is pending.
- R11: An accepted legal request raises txn_valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_we | input | 1 | Load the extension register |
| ext_wdata | input | 3 | New extension value (bus address bits 31:29) |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle |
| req_addr | input | 31 | Host offset into the sparse region |
| req_io | input | 1 | 1 = I/O sparse, 0 = memory sparse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_quad | input | 1 | 64-bit request split into two longwords |
| req_wdata | input | 64 | Host write data, aligned to bit 0 |
| req_err | output | 1 | One-cycle pulse: request refused |
| txn_valid | output | 1 | Bus transaction valid |
| txn_ready | input | 1 | Bus accepts the transaction |
| txn_addr | output | 32 | Bus byte address |
| txn_be_n | output | 4 | Active-low byte enables |
| txn_write | output | 1 | Transaction is a write |
| txn_io | output | 1 | Transaction targets I/O space |
| txn_wdata | output | 32 | Lane-steered write data |
| cpl_valid | input | 1 | Read completion pulse from the bus |
| cpl_data | input | 32 | Read completion data |
| rsp_valid | output | 1 | Read response to the host valid |
| rsp_ready | input | 1 | Host accepts the read response |
| rsp_data | output | 64 | Read data aligned to bit 0 |

## Verification
The bench builds the block with its default parameters: a 26-bit low address field, a 3-bit extension register, a shift of five and a 32-bit bus. With these values it can reach the highest low-field address, every byte position, and a non-zero extension value. Those cases show that the extension bits land above the three forced-zero bits and never appear in I/O addresses. The 4-byte step between the two halves of a quad request is checked against this bus width.

// File: rtl/sparse_xlat_pkg.sv
package sparse_xlat_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BAD  = 2'b10,
    SZ_LONG = 2'b11
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } xlat_state_e;

endpackage

// File: rtl/ext_addr_reg.sv
module ext_addr_reg #(
  parameter int EXT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [EXT_W-1:0] wdata,
  output logic [EXT_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/sparse_decode.sv
module sparse_decode
  import sparse_xlat_pkg::*;
#(
  parameter int LOW_AW = 26,
  parameter int SHIFT  = 5,
  parameter int LANES  = 4,
  localparam int PW    = $clog2(LANES),
  localparam int CODE_LSB = SHIFT - 2,
  localparam int IN_W  = LOW_AW + SHIFT - CODE_LSB
) (
  input  logic [IN_W-1:0]   offset,
  input  logic              quad,
  output logic [LOW_AW-1:0] low,
  output logic [PW-1:0]     pos,
  output xfer_size_e        size,
  output logic [LANES-1:0]  be_n,
  output logic              illegal
);
  logic [LANES-1:0] lane_on;

  assign low  = offset[IN_W-1 -: LOW_AW];
  assign size = xfer_size_e'(offset[1:0]);
  assign pos  = low[PW-1:0];

  always_comb begin
    case (size)
      SZ_BYTE: lane_on = LANES'(1) << pos;
      SZ_WORD: lane_on = LANES'(3) << pos;
      default: lane_on = '1;
    endcase
    be_n = ~lane_on;
  end

  assign illegal = (size == SZ_BAD)
                 || (size == SZ_WORD && pos == PW'(LANES - 1))
                 || (quad && size != SZ_LONG);
endmodule

// File: rtl/lane_insert.sv
module lane_insert
  import sparse_xlat_pkg::*;
#(
  parameter int DW = 32,
  localparam int PW = $clog2(DW / 8)
) (
  input  logic [DW-1:0] din,
  input  xfer_size_e    size,
  input  logic [PW-1:0] pos,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] keep;
  always_comb begin
    case (size)
      SZ_BYTE: keep = DW'(8'hFF);
      SZ_WORD: keep = DW'(16'hFFFF);
      default: keep = '1;
    endcase
    dout = (din & keep) << {pos, 3'b000};
  end
endmodule

// File: rtl/lane_extract.sv
module lane_extract
  import sparse_xlat_pkg::*;
#(
  parameter int DW = 32,
  localparam int PW = $clog2(DW / 8)
) (
  input  logic [DW-1:0] din,
  input  xfer_size_e    size,
  input  logic [PW-1:0] pos,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] keep;
  always_comb begin
    case (size)
      SZ_BYTE: keep = DW'(8'hFF);
      SZ_WORD: keep = DW'(16'hFFFF);
      default: keep = '1;
    endcase
    dout = (din >> {pos, 3'b000}) & keep;
  end
endmodule

// File: rtl/sparse_xlat.sv
module sparse_xlat
  import sparse_xlat_pkg::*;
#(
  parameter int LOW_AW = 26,
  parameter int EXT_W  = 3,
  parameter int SHIFT  = 5,
  parameter int DW     = 32,
  localparam int LANES   = DW / 8,
  localparam int PW      = $clog2(LANES),
  localparam int HOST_AW = LOW_AW + SHIFT,
  localparam int CODE_LSB = SHIFT - 2,
  localparam int GAP_W   = DW - EXT_W - LOW_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_we,
  input  logic [EXT_W-1:0]   ext_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic               req_io,
  input  logic               req_write,
  input  logic               req_quad,
  input  logic [2*DW-1:0]    req_wdata,
  output logic               req_err,
  output logic               txn_valid,
  input  logic               txn_ready,
  output logic [DW-1:0]      txn_addr,
  output logic [LANES-1:0]   txn_be_n,
  output logic               txn_write,
  output logic               txn_io,
  output logic [DW-1:0]      txn_wdata,
  input  logic               cpl_valid,
  input  logic [DW-1:0]      cpl_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [2*DW-1:0]    rsp_data
);
  xlat_state_e      state;
  logic [EXT_W-1:0] ext_cur;

  logic [LOW_AW-1:0] dec_low;
  logic [PW-1:0]     dec_pos;
  xfer_size_e        dec_size;
  logic [LANES-1:0]  dec_be_n;
  logic              dec_illegal;
  logic [DW-1:0]     steered_wd;
  logic [DW-1:0]     extracted_rd;

  logic [LOW_AW-1:0] low_q;
  logic [EXT_W-1:0]  ext_q;
  logic [PW-1:0]     pos_q;
  xfer_size_e        size_q;
  logic [LANES-1:0]  be_q;
  logic              io_q, wr_q, quad_q, phase_q, err_q;
  logic [DW-1:0]     wd0_q, wd1_q, rd_lo_q, rd_hi_q;

  ext_addr_reg #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .we(ext_we), .wdata(ext_wdata), .q(ext_cur)
  );

  sparse_decode #(.LOW_AW(LOW_AW), .SHIFT(SHIFT), .LANES(LANES)) u_dec (
    .offset (req_addr[HOST_AW-1:CODE_LSB]),
    .quad   (req_quad),
    .low    (dec_low),
    .pos    (dec_pos),
    .size   (dec_size),
    .be_n   (dec_be_n),
    .illegal(dec_illegal)
  );

  lane_insert #(.DW(DW)) u_ins (
    .din(req_wdata[DW-1:0]), .size(dec_size), .pos(dec_pos), .dout(steered_wd)
  );

  lane_extract #(.DW(DW)) u_ext_rd (
    .din(cpl_data), .size(size_q), .pos(pos_q), .dout(extracted_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      low_q   <= '0;
      ext_q   <= '0;
      pos_q   <= '0;
      size_q  <= SZ_BYTE;
      be_q    <= '1;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      quad_q  <= 1'b0;
      phase_q <= 1'b0;
      err_q   <= 1'b0;
      wd0_q   <= '0;
      wd1_q   <= '0;
      rd_lo_q <= '0;
      rd_hi_q <= '0;
    end else begin
      err_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (dec_illegal) begin
              err_q <= 1'b1;
            end else begin
              low_q   <= dec_low;
              ext_q   <= ext_cur;
              pos_q   <= dec_pos;
              size_q  <= dec_size;
              be_q    <= dec_be_n;
              io_q    <= req_io;
              wr_q    <= req_write;
              quad_q  <= req_quad;
              phase_q <= 1'b0;
              wd0_q   <= steered_wd;
              wd1_q   <= req_wdata[2*DW-1:DW];
              rd_lo_q <= '0;
              rd_hi_q <= '0;
              state   <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (txn_ready) begin
            if (!wr_q) begin
              state <= ST_WAIT;
            end else if (quad_q && !phase_q) begin
              phase_q <= 1'b1;
              low_q   <= low_q + LOW_AW'(LANES);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WAIT: begin
          if (cpl_valid) begin
            if (!phase_q) rd_lo_q <= extracted_rd;
            else          rd_hi_q <= cpl_data;
            if (quad_q && !phase_q) begin
              phase_q <= 1'b1;
              low_q   <= low_q + LOW_AW'(LANES);
              state   <= ST_ISSUE;
            end else begin
              state <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign req_err   = err_q;
  assign txn_valid = (state == ST_ISSUE);
  assign txn_addr  = io_q ? {{(DW-LOW_AW){1'b0}}, low_q}
                          : {ext_q, {GAP_W{1'b0}}, low_q};
  assign txn_be_n  = be_q;
  assign txn_write = wr_q;
  assign txn_io    = io_q;
  assign txn_wdata = phase_q ? wd1_q : wd0_q;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_data  = {rd_hi_q, rd_lo_q};
endmodule

// File: rtl/sparse_xlat_chk.sv
module sparse_xlat_chk #(
  parameter int LOW_AW = 26,
  parameter int EXT_W  = 3,
  parameter int DW     = 32,
  localparam int LANES = DW / 8,
  localparam int GAP_W = DW - EXT_W - LOW_AW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_err,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [DW-1:0]    txn_addr,
  input logic [LANES-1:0] txn_be_n,
  input logic [DW-1:0]    txn_wdata,
  input logic             txn_io,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [2*DW-1:0]  rsp_data
);
  // R10: a stalled transaction keeps its fields
  p_txn_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr)
      && $stable(txn_be_n) && $stable(txn_wdata));

  // R10: a stalled response keeps its data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  // R10: no new request while work is pending
  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (txn_valid || rsp_valid)));

  // R3: one, two or all lanes enabled
  p_be_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ($countones(~txn_be_n) == 1 || $countones(~txn_be_n) == 2
                   || $countones(~txn_be_n) == LANES));

  // R1: forced-zero gap below the extension bits on memory cycles
  p_mem_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_io |-> txn_addr[DW-EXT_W-1 -: GAP_W] == '0);

  // R7: I/O addresses never carry upper bits
  p_io_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_io |-> txn_addr[DW-1:LOW_AW] == '0);

  // R8: a refusal never coincides with a transaction
  p_err_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !txn_valid);

  // R11: acceptance leads to a transaction or a refusal next cycle
  p_accept_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> txn_valid || req_err);
endmodule

bind sparse_xlat sparse_xlat_chk #(.LOW_AW(LOW_AW), .EXT_W(EXT_W), .DW(DW)) u_chk (.*);

// File: tb/sparse_xlat_bench.sv
`timescale 1ns/1ps
module sparse_xlat_bench;
  localparam int HOST_AW = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_we = 1'b0;
  logic [2:0]  ext_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [HOST_AW-1:0] req_addr = '0;
  logic        req_io = 1'b0, req_write = 1'b0, req_quad = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        req_err;
  logic        txn_valid;
  logic        txn_ready = 1'b0;
  logic [31:0] txn_addr;
  logic [3:0]  txn_be_n;
  logic        txn_write, txn_io;
  logic [31:0] txn_wdata;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sparse_xlat u_sparse_xlat (.*);

  function automatic logic [HOST_AW-1:0] mk(input logic [25:0] low, input logic [1:0] code);
    return {low, code, 3'b000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_ext(input logic [2:0] v);
    ext_we = 1'b1; ext_wdata = v;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic host_req(input logic [HOST_AW-1:0] a, input logic io, input logic wr,
                          input logic quad, input logic [63:0] wd);
    chk("R10 req_ready idle", req_ready, 1);
    req_addr = a; req_io = io; req_write = wr; req_quad = quad; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_txn(input string tag, input logic [31:0] addr, input logic [3:0] be,
                            input logic wr, input logic io, input logic [31:0] wd, input bit stall);
    int n = 0;
    while (!txn_valid && n < 20) begin @(negedge clk); n++; end
    chk({tag, " txn_valid"}, txn_valid, 1);
    chk({tag, " addr"}, txn_addr, addr);
    chk({tag, " be_n"}, txn_be_n, be);
    chk({tag, " write"}, txn_write, wr);
    chk({tag, " io"}, txn_io, io);
    if (wr) chk({tag, " wdata"}, txn_wdata, wd);
    if (stall) begin
      @(negedge clk);
      chk("R10 stalled txn addr", txn_addr, addr);
      chk("R10 stalled txn valid", txn_valid, 1);
    end
    txn_ready = 1'b1;
    @(negedge clk);
    txn_ready = 1'b0;
  endtask

  task automatic give_cpl(input logic [31:0] d);
    cpl_valid = 1'b1; cpl_data = d;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [63:0] d, input bit stall);
    int n = 0;
    while (!rsp_valid && n < 20) begin @(negedge clk); n++; end
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_data"}, rsp_data, d);
    if (stall) begin
      @(negedge clk);
      chk("R10 stalled rsp data", rsp_data, d);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset req_ready", req_ready, 1);
    chk("R10 reset txn_valid", txn_valid, 0);
    chk("R10 reset rsp_valid", rsp_valid, 0);
    chk("R8 reset req_err", req_err, 0);
    // R9: extension resets to zero; R11 txn next cycle
    host_req(mk(26'h0000040, 2'b00), 0, 1, 0, 64'h5A);
    chk("R11 txn right after accept", txn_valid, 1);
    expect_txn("R9 ext reset", 32'h0000_0040, 4'b1110, 1, 0, 32'h5A, 0);
  endtask

  task automatic t_byte_write();
    set_ext(3'b101);
    host_req(mk(26'h0123457, 2'b00), 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFA5);
    expect_txn("R1 R3 R4 byte write pos3", 32'hA012_3457, 4'b0111, 1, 0, 32'hA500_0000, 1);
  endtask

  task automatic t_word_write();
    host_req(mk(26'h0000102, 2'b01), 0, 1, 0, 64'h1234_BEEF);
    expect_txn("R2 R3 R4 word write pos2", 32'hA000_0102, 4'b0011, 1, 0, 32'hBEEF_0000, 0);
  endtask

  task automatic t_long_write();
    host_req(mk(26'h3FFFFFC, 2'b11), 0, 1, 0, 64'h1234_5678);
    expect_txn("R1 R2 long write top", 32'hA3FF_FFFC, 4'b0000, 1, 0, 32'h1234_5678, 0);
  endtask

  task automatic t_byte_read();
    host_req(mk(26'h0000011, 2'b00), 0, 0, 0, 64'h0);
    expect_txn("R3 byte read pos1", 32'hA000_0011, 4'b1101, 0, 0, 32'h0, 0);
    give_cpl(32'h1122_3344);
    expect_rsp("R5 byte read", 64'h33, 1);
  endtask

  task automatic t_word_read();
    host_req(mk(26'h0000002, 2'b01), 0, 0, 0, 64'h0);
    expect_txn("R3 word read pos2", 32'hA000_0002, 4'b0011, 0, 0, 32'h0, 0);
    give_cpl(32'hCAFE_BABE);
    expect_rsp("R5 word read", 64'hCAFE, 0);
  endtask

  task automatic t_quad_write();
    host_req(mk(26'h0000100, 2'b11), 0, 1, 1, 64'h8765_4321_1234_5678);
    expect_txn("R6 quad write lo", 32'hA000_0100, 4'b0000, 1, 0, 32'h1234_5678, 0);
    expect_txn("R6 quad write hi", 32'hA000_0104, 4'b0000, 1, 0, 32'h8765_4321, 1);
    chk("R6 quad write done", req_ready, 1);
  endtask

  task automatic t_quad_read();
    host_req(mk(26'h0000200, 2'b11), 0, 0, 1, 64'h0);
    expect_txn("R6 quad read lo", 32'hA000_0200, 4'b0000, 0, 0, 32'h0, 0);
    give_cpl(32'hAAAA_5555);
    expect_txn("R6 quad read hi", 32'hA000_0204, 4'b0000, 0, 0, 32'h0, 0);
    give_cpl(32'h0F0F_0F0F);
    expect_rsp("R6 quad read", 64'h0F0F_0F0F_AAAA_5555, 0);
  endtask

  task automatic t_io();
    host_req(mk(26'h2000060, 2'b00), 1, 1, 0, 64'h3C);
    expect_txn("R7 io byte write", 32'h0200_0060, 4'b1110, 1, 1, 32'h3C, 0);
    host_req(mk(26'h0000083, 2'b00), 1, 0, 0, 64'h0);
    expect_txn("R7 io byte read", 32'h0000_0083, 4'b0111, 0, 1, 32'h0, 0);
    give_cpl(32'h9900_0000);
    expect_rsp("R7 R5 io read", 64'h99, 0);
  endtask

  task automatic t_illegal(input string tag, input logic [HOST_AW-1:0] a, input logic quad);
    host_req(a, 0, 1, quad, 64'hFFFF);
    chk({tag, " R8 req_err"}, req_err, 1);
    chk({tag, " R8 no txn"}, txn_valid, 0);
    chk({tag, " R8 ready"}, req_ready, 1);
    @(negedge clk);
    chk({tag, " R8 err cleared"}, req_err, 0);
    chk({tag, " R8 still no txn"}, txn_valid, 0);
  endtask

  task automatic t_ext_timing();
    ext_we = 1'b1; ext_wdata = 3'b010;
    host_req(mk(26'h0000040, 2'b11), 0, 1, 0, 64'h1);
    ext_we = 1'b0;
    expect_txn("R9 same-cycle old ext", 32'hA000_0040, 4'b0000, 1, 0, 32'h1, 0);
    host_req(mk(26'h0000040, 2'b11), 0, 1, 0, 64'h2);
    expect_txn("R9 new ext", 32'h4000_0040, 4'b0000, 1, 0, 32'h2, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_word_write();
    t_long_write();
    t_byte_read();
    t_word_read();
    t_quad_write();
    t_quad_read();
    t_io();
    t_illegal("word pos3", mk(26'h0000003, 2'b01), 0);
    t_illegal("bad code", mk(26'h0000000, 2'b10), 0);
    t_illegal("quad byte", mk(26'h0000000, 2'b00), 1);
    t_ext_timing();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule